// File: doc/BRIEF.md
# Dithered Half-Period PWM Channel

This block drives one pulse-width modulated line from an internal up-counter. A period word and a duty word, both 11 bits wide, set the waveform. In the normal mode the counter runs once per period and the output goes high when the count reaches the duty value. It stays high until the period ends.

In the dithered mode each period is split into two equal halves. The counter runs over half the period twice. The upper ten bits of the duty word set the switch-on point in both halves. When the duty's lowest bit is set, the switch-on point of the second half moves one count later. The extra resolution bit is thus spread over the period, and the line makes four transitions per period instead of two.

The duty word counts the low time at the start of the period (or of each half in dithered mode). Period, duty and mode are taken into shadow registers at full-period boundaries, so a running period never mixes settings. The mode input is accepted only while the channel is idle.

Top module: `dpwm_channel`

## Requirements
- R1: In dithered mode the counter runs from 0 to per[10:1]−1 and wraps. Two such runs form one full period of `per` clock cycles.
- R2: The output is registered, so pwm_o shows in cycle t+1 the level the count had in cycle t. In the first half, that level is high when count ≥ duty[10:1] and low otherwise, so the line drops once the counter wraps.
- R3: In the second half of a dithered period the compare value is duty[10:1] + duty[0]. The level rule is the same as in the first half.
- R4: With per=200 and duty=31 in dithered mode, a full period holds 169 high cycles and the line makes 4 transitions. The switch-on points are count 15 in the first half and count 16 in the second half.
- R5: In normal mode the counter runs from 0 to per−1, the compare value is the full 11-bit duty, and the line makes 2 transitions per period.
- R6: Period and duty changes take effect only at a full-period boundary or while the channel is not running. A mid-period change leaves the current period unchanged.
- R7: A change of dith_en while chan_en=1 and per≠0 has no effect on the waveform. The mode is captured only while the channel is disabled or per=0.
- R8: With chan_en=0, one cycle later pwm_o is low, and the counter and half-period select return to count 0 of the first half. Reset gives the same state.
- R9: A duty of 0 holds pwm_o high for the whole period. A duty at or above per holds it low. Neither case has any transition.
- R10: A half length of zero (per=0 in either mode, or per=1 in dithered mode) keeps pwm_o low and the counter at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| chan_en | input | 1 | Channel enable |
| dith_en | input | 1 | Dithered half-period mode request |
| per | input | 11 | Period length in clock cycles |
| duty | input | 11 | Low-time count at the start of a period or half |
| pwm_o | output | 1 | PWM line |

## Verification
The assertions assume that rst_n is low for at least one edge before the first use. They also assume the inputs are stable around the rising edge. Beyond that they place no limit on duty, period or mode changes, because mid-period updates and blocked mode changes are part of the behaviour under test. The stimulus drives every input on the falling edge. It uses an odd period only in the dithered case where the half length is zero, since odd dithered periods are outside the intended use. It changes period, duty and mode both during a period and while the channel is idle.

// File: rtl/dpwm_pkg.sv
package dpwm_pkg;
  localparam int unsigned CNT_W = 11;
  typedef logic [CNT_W-1:0] cnt_t;
endpackage

// File: rtl/dpwm_shadow.sv
module dpwm_shadow #(
  parameter int unsigned W = dpwm_pkg::CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         chan_en,
  input  logic         dith_en,
  input  logic [W-1:0] per,
  input  logic [W-1:0] duty,
  input  logic         load,
  output logic [W-1:0] sh_per,
  output logic [W-1:0] sh_duty,
  output logic         sh_dith
);
  logic         mode_q, mode_d, mode_ce;
  logic [W-1:0] per_d, duty_d;
  logic         dith_d;

  always_comb begin
    mode_ce = !chan_en || (per == '0);
    mode_d  = mode_ce ? dith_en : mode_q;
    per_d   = load ? per     : sh_per;
    duty_d  = load ? duty    : sh_duty;
    dith_d  = load ? mode_q  : sh_dith;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      sh_per  <= '0;
      sh_duty <= '0;
      sh_dith <= 1'b0;
    end else begin
      mode_q  <= mode_d;
      sh_per  <= per_d;
      sh_duty <= duty_d;
      sh_dith <= dith_d;
    end
  end

  assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(sh_per) && $stable(sh_duty) && $stable(sh_dith)));

  assert_mode_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && per != '0) |=> $stable(mode_q));
endmodule

// File: rtl/dpwm_timebase.sv
module dpwm_timebase #(
  parameter int unsigned W = dpwm_pkg::CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         chan_en,
  input  logic [W-1:0] sh_per,
  input  logic         sh_dith,
  output logic [W-1:0] cnt,
  output logic         half,
  output logic         running,
  output logic         full_end
);
  logic [W-1:0] span;
  logic         last;
  logic [W-1:0] cnt_d;
  logic         half_d;

  always_comb begin
    span     = sh_dith ? {1'b0, sh_per[W-1:1]} : sh_per;
    running  = chan_en && (span != '0);
    last     = running && (cnt == span - 1'b1);
    full_end = last && (half || !sh_dith);
    if (!running) begin
      cnt_d  = '0;
      half_d = 1'b0;
    end else if (last) begin
      cnt_d  = '0;
      half_d = sh_dith ? ~half : 1'b0;
    end else begin
      cnt_d  = cnt + 1'b1;
      half_d = half;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      half <= 1'b0;
    end else begin
      cnt  <= cnt_d;
      half <= half_d;
    end
  end

  assert_cnt_in_span_R1: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt < span));

  assert_half_on_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (half != $past(half)) |-> ($past(last) || !$past(running)));

  assert_idle_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> (cnt == '0 && !half));

  assert_normal_one_half_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (running && !sh_dith) |-> !half);
endmodule

// File: rtl/dpwm_compare.sv
module dpwm_compare #(
  parameter int unsigned W = dpwm_pkg::CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         running,
  input  logic         half,
  input  logic         sh_dith,
  input  logic [W-1:0] sh_duty,
  input  logic [W-1:0] sh_per,
  input  logic [W-1:0] cnt,
  output logic         pwm_o
);
  logic [W-1:0] thr_first, thr_second, thr;
  logic         lvl;

  always_comb begin
    thr_first  = {1'b0, sh_duty[W-1:1]};
    thr_second = thr_first + {{(W-1){1'b0}}, sh_duty[0]};
    if (sh_dith) thr = half ? thr_second : thr_first;
    else         thr = sh_duty;
    lvl = running && (cnt >= thr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_o <= 1'b0;
    else        pwm_o <= lvl;
  end

  assert_zero_duty_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (running && sh_duty == '0) |=> pwm_o);

  assert_full_duty_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (running && sh_duty >= sh_per) |=> !pwm_o);

  assert_idle_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !running |=> !pwm_o);

  assert_second_half_later_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (running && sh_dith && half && cnt == thr_first && sh_duty[0]) |=> !pwm_o);
endmodule

// File: rtl/dpwm_channel.sv
module dpwm_channel #(
  parameter int unsigned W = dpwm_pkg::CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         chan_en,
  input  logic         dith_en,
  input  logic [W-1:0] per,
  input  logic [W-1:0] duty,
  output logic         pwm_o
);
  logic [W-1:0] sh_per, sh_duty, cnt;
  logic         sh_dith, half, running, full_end, load;

  assign load = !running || full_end;

  dpwm_shadow #(.W(W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .dith_en(dith_en),
    .per(per), .duty(duty), .load(load),
    .sh_per(sh_per), .sh_duty(sh_duty), .sh_dith(sh_dith)
  );

  dpwm_timebase #(.W(W)) u_timebase (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en),
    .sh_per(sh_per), .sh_dith(sh_dith),
    .cnt(cnt), .half(half), .running(running), .full_end(full_end)
  );

  dpwm_compare #(.W(W)) u_compare (
    .clk(clk), .rst_n(rst_n), .running(running), .half(half),
    .sh_dith(sh_dith), .sh_duty(sh_duty), .sh_per(sh_per),
    .cnt(cnt), .pwm_o(pwm_o)
  );

  assert_reset_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !pwm_o);
endmodule

// File: tb/dpwm_channel_tb.sv
module dpwm_channel_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chan_en = 1'b0;
  logic        dith_en = 1'b0;
  logic [10:0] per = '0;
  logic [10:0] duty = '0;
  logic        pwm_o;

  int n_cmp = 0;
  int n_bad = 0;
  string phase = "R8";

  always #2.5 clk = ~clk;

  dpwm_channel dut_i (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .dith_en(dith_en),
    .per(per), .duty(duty), .pwm_o(pwm_o)
  );

  // behavioural reference
  int m_cnt, m_half, m_per, m_duty, m_dith, m_mode;
  bit exp_pwm;

  always @(posedge clk) begin
    int len, thr, nxt_cnt, nxt_half;
    bit run, fin, ld;
    if (!rst_n) begin
      m_cnt = 0; m_half = 0; m_per = 0; m_duty = 0; m_dith = 0; m_mode = 0;
      exp_pwm = 0;
    end else begin
      len = m_dith ? (m_per / 2) : m_per;
      run = chan_en && (len > 0);
      if (!m_dith) thr = m_duty;
      else if (m_half == 0) thr = m_duty / 2;
      else thr = m_duty / 2 + (m_duty % 2);
      exp_pwm = run && (m_cnt >= thr);
      fin = run && (m_cnt == len - 1);
      ld = !run || (fin && (m_half == 1 || !m_dith));
      if (!run) begin nxt_cnt = 0; nxt_half = 0; end
      else if (fin) begin nxt_cnt = 0; nxt_half = m_dith ? 1 - m_half : 0; end
      else begin nxt_cnt = m_cnt + 1; nxt_half = m_half; end
      if (ld) begin m_per = per; m_duty = duty; m_dith = m_mode; end
      if (!chan_en || per == 0) m_mode = dith_en;
      m_cnt = nxt_cnt; m_half = nxt_half;
    end
  end

  always @(negedge clk) begin
    n_cmp++;
    if (pwm_o !== exp_pwm) begin
      n_bad++;
      $display("FAIL %s: pwm_o=%0b expected %0b at %0t", phase, pwm_o, exp_pwm, $time);
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic count_window(input int n, output int hi, output int edg);
    bit prev;
    hi = 0; edg = 0;
    @(negedge clk); prev = pwm_o;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_o) hi++;
      if (pwm_o != prev) edg++;
      prev = pwm_o;
    end
  endtask

  task automatic check_val(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle_then(input bit dm, input int p, input int d);
    chan_en = 0; wait_cyc(2);
    dith_en = dm; per = p[10:0]; duty = d[10:0];
    wait_cyc(3);
    chan_en = 1;
  endtask

  initial begin
    int hi, edg;
    wait_cyc(3);
    check_val("R8 reset", pwm_o, 0);
    rst_n = 1;
    wait_cyc(2);

    phase = "R4";
    idle_then(1, 200, 31);
    wait_cyc(400);
    count_window(400, hi, edg);
    check_val("R4 high count", hi, 338);
    check_val("R4 edges", edg, 8);

    phase = "R2";
    idle_then(1, 200, 30);
    wait_cyc(400);
    count_window(200, hi, edg);
    check_val("R2 high count", hi, 170);
    check_val("R3 edges even duty", edg, 4);

    phase = "R6";
    wait_cyc(37);
    duty = 51; per = 120;
    wait_cyc(500);
    count_window(360, hi, edg);
    check_val("R6 high count", hi, 3 * (120 - 51));
    check_val("R1 edges", edg, 12);

    phase = "R7";
    dith_en = 0;
    wait_cyc(360);
    count_window(120, hi, edg);
    check_val("R7 still dithered edges", edg, 4);

    phase = "R5";
    idle_then(0, 50, 20);
    wait_cyc(100);
    count_window(100, hi, edg);
    check_val("R5 high count", hi, 60);
    check_val("R5 edges", edg, 4);

    phase = "R9";
    idle_then(1, 200, 0);
    wait_cyc(250);
    count_window(200, hi, edg);
    check_val("R9 zero duty high", hi, 200);
    idle_then(1, 200, 250);
    wait_cyc(250);
    count_window(200, hi, edg);
    check_val("R9 full duty low", hi, 0);
    check_val("R9 no edges", edg, 0);

    phase = "R10";
    idle_then(1, 0, 5);
    count_window(50, hi, edg);
    check_val("R10 zero period", hi, 0);
    idle_then(1, 1, 0);
    count_window(50, hi, edg);
    check_val("R10 unit period dithered", hi, 0);

    phase = "R8";
    idle_then(1, 40, 3);
    wait_cyc(57);
    chan_en = 0;
    wait_cyc(2);
    check_val("R8 disable low", pwm_o, 0);
    wait_cyc(5);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(5 * 20000);
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule